// File: doc/BRIEF.md
# Two-Stage Card Clock Generator

This block derives a card clock for each of several card slots (two by default) from a single source clock, nominally 160 MHz. A shared host stage divides the source down. A separate card stage for each slot then divides that result further, or is bypassed when its setting is zero. Every slot has a clock enable and a low-power option. When the low-power option is set, the slot's clock stops while the slot reports itself idle.

Software writes new divider, enable and low-power values into shadow registers through a small register-style write port. Those values reach the running clock only after a start request has been accepted. The start bit stays set until the block loads the shadow values, and it then clears. Loading happens only while every slot clock is low, so no shortened pulse appears.

A start request made while the command path is busy is refused. In that case the block raises a locked error flag, which software clears by writing 1 and then answers by issuing the request again. Changing frequency therefore takes three steps: turn the slot off and update, program the dividers and update, then turn the slot back on and update.

Top module: `card_clk_gen`

## Requirements
- R1: After reset every card clock is low, the start bit and the locked error are clear, and all divider, enable and low-power values are zero. Enabling a slot with these zero dividers gives a card clock period of 2 source cycles.
- R2: The host stage emits one tick every H source cycles, where H is the host divider value written at address 0 (bits 4:0) and H of 0 or 1 means every cycle. With the card stage bypassed (M = 0), the card clock toggles on every host tick, giving a period of 2*H source cycles.
- R3: With card divider value M >= 1, the card clock toggles every M host ticks, giving a period of 2*H*M source cycles. H = 10 with M = 20 gives a period of 400 source cycles, which is 400 kHz from 160 MHz.
- R4: Slot i takes its card divider from address 2+i (bits 7:0), and each slot's divider acts only on that slot's clock.
- R5: Writes through the write port change only the shadow values. The running clocks keep their old rates until an update is accepted.
- R6: An accepted start request sets the start bit (upd_busy) at the next clock edge. The bit stays set while any card clock is high, and it clears when the shadow values are loaded.
- R7: A start request while cmd_busy is high sets lock_err, leaves the start bit clear and loads nothing. A pulse on err_clr clears lock_err, and a new request made when cmd_busy is low then succeeds.
- R8: Address 1 bits [NUM_SLOTS-1:0] are the slot enables. A slot whose loaded enable is 0 holds its card clock low.
- R9: Address 1 bits [2*NUM_SLOTS-1:NUM_SLOTS] are the low-power bits. With low-power set, an enabled slot's clock stays low while slot_busy for that slot is low, and runs at its programmed rate while slot_busy is high.
- R10: Each high pulse of a card clock lasts exactly H*max(M,1) source cycles. Gating changes take effect only while the undivided slot clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | ADDR_W | 0 host divider, 1 enables and low-power bits, 2+i card divider of slot i |
| wr_data | input | DATA_W | Write data |
| upd_start | input | 1 | Request to load the shadow values (sets the start bit) |
| err_clr | input | 1 | Write-1 clear of the locked error |
| cmd_busy | input | 1 | Command path busy; a request arriving now is refused |
| slot_busy | input | NUM_SLOTS | Per-slot activity, used by low-power gating |
| upd_busy | output | 1 | Start bit, set until the update is loaded |
| lock_err | output | 1 | Locked error flag |
| card_clk | output | NUM_SLOTS | Generated card clocks |

## Verification
The bench measures the high time and the period of the card clock for a range of host and card divider pairs. These include bypass with a divide-by-1 host stage and the 400-cycle probing pair, so an off-by-one counter or a card stage that divides by M instead of 2M shows up as a wrong period. It writes shadow values without issuing an update to catch a design that leaks writes straight into the live path. It also makes a request while the command path is busy to catch one that loads anyway or leaves the start bit stuck. Disabled and idle low-power slots are watched for any high level, and two slots with different card dividers are run together to expose swapped or shared divider registers.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  // write port address map
  localparam int ADDR_HOST  = 0;
  localparam int ADDR_CTRL  = 1;
  localparam int ADDR_CDIV0 = 2;
endpackage

// File: rtl/card_clk_host_div.sv
module card_clk_host_div #(
  parameter int HDIV_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [HDIV_W-1:0] hdiv,
  output logic              tick
);
  logic [HDIV_W-1:0] cnt_q;

  always_comb begin
    if (hdiv <= HDIV_W'(1)) tick = 1'b1;
    else                    tick = (cnt_q == hdiv - HDIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || load)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + HDIV_W'(1);
  end

  // R2: with a divider above 1 two ticks are never adjacent
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && hdiv > HDIV_W'(1) && !load) |=> !tick);
endmodule

// File: rtl/card_clk_slot.sv
module card_clk_slot #(
  parameter int CDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              tick,
  input  logic [CDIV_W-1:0] cdiv,
  input  logic              en,
  input  logic              lp,
  input  logic              busy,
  output logic              card_clk
);
  logic [CDIV_W-1:0] ccnt_q;
  logic              phase_q, gate_q, clk_q;
  logic              last_c, phase_n, gate_n, want;

  always_comb begin
    last_c  = (cdiv == '0) ? 1'b1 : (ccnt_q == cdiv - CDIV_W'(1));
    want    = en && (!lp || busy);
    if (load)                phase_n = 1'b0;
    else if (tick && last_c) phase_n = !phase_q;
    else                     phase_n = phase_q;
    // gate may only move while the undivided clock is low
    if (load)         gate_n = 1'b0;
    else if (phase_q) gate_n = gate_q;
    else              gate_n = want;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ccnt_q  <= '0;
      phase_q <= 1'b0;
      gate_q  <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      if (load)      ccnt_q <= '0;
      else if (tick) ccnt_q <= last_c ? '0 : ccnt_q + CDIV_W'(1);
      phase_q <= phase_n;
      gate_q  <= gate_n;
      clk_q   <= phase_n && gate_n;
    end
  end

  assign card_clk = clk_q;

  // R10: gate is steady across a high phase of the raw clock
  a_r10_gate_steady: assert property (@(posedge clk) disable iff (rst)
    (phase_q && $past(phase_q)) |-> $stable(gate_q));
  // R8: a closed gate with the slot disabled keeps the output low
  a_r8_off_low: assert property (@(posedge clk) disable iff (rst)
    (!en && !gate_q) |=> !card_clk);
endmodule

// File: rtl/card_clk_upd.sv
module card_clk_upd
  import card_clk_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int HDIV_W    = 5,
  parameter int CDIV_W    = 8,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             upd_start,
  input  logic                             err_clr,
  input  logic                             cmd_busy,
  input  logic                             any_high,
  output logic                             load,
  output logic                             upd_busy,
  output logic                             lock_err,
  output logic [HDIV_W-1:0]                live_hdiv,
  output logic [NUM_SLOTS-1:0][CDIV_W-1:0] live_cdiv,
  output logic [NUM_SLOTS-1:0]             live_en,
  output logic [NUM_SLOTS-1:0]             live_lp
);
  logic [HDIV_W-1:0]                sh_hdiv;
  logic [NUM_SLOTS-1:0][CDIV_W-1:0] sh_cdiv;
  logic [NUM_SLOTS-1:0]             sh_en, sh_lp;
  logic pend_q, err_q, hit_host, hit_ctrl, reject, accept;

  assign hit_host = wr_en && (wr_addr == ADDR_W'(ADDR_HOST));
  assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign reject   = upd_start && cmd_busy && !pend_q;
  assign accept   = upd_start && !cmd_busy && !pend_q;
  assign load     = pend_q && !any_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_hdiv <= '0;
      sh_en   <= '0;
      sh_lp   <= '0;
    end else begin
      if (hit_host) sh_hdiv <= wr_data[HDIV_W-1:0];
      if (hit_ctrl) begin
        sh_en <= wr_data[NUM_SLOTS-1:0];
        sh_lp <= wr_data[2*NUM_SLOTS-1:NUM_SLOTS];
      end
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sh
    logic hit_c;
    assign hit_c = wr_en && (wr_addr == ADDR_W'(ADDR_CDIV0 + i));
    always_ff @(posedge clk) begin
      if (rst)        sh_cdiv[i] <= '0;
      else if (hit_c) sh_cdiv[i] <= wr_data[CDIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      err_q     <= 1'b0;
      live_hdiv <= '0;
      live_cdiv <= '0;
      live_en   <= '0;
      live_lp   <= '0;
    end else begin
      if (accept)    pend_q <= 1'b1;
      else if (load) pend_q <= 1'b0;
      if (reject)       err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (load) begin
        live_hdiv <= sh_hdiv;
        live_cdiv <= sh_cdiv;
        live_en   <= sh_en;
        live_lp   <= sh_lp;
      end
    end
  end

  assign upd_busy = pend_q;
  assign lock_err = err_q;

  // R7: a refused request flags the error and leaves the start bit clear
  a_r7_reject: assert property (@(posedge clk) disable iff (rst)
    (upd_start && cmd_busy && !upd_busy) |=> (lock_err && !upd_busy));
  // R7: write-1 clear
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !(upd_start && cmd_busy && !upd_busy)) |=> !lock_err);
  // R6: an accepted request sets the start bit
  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    (upd_start && !cmd_busy && !upd_busy) |=> upd_busy);
  // R6: no load while any card clock is high
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (upd_busy && any_high) |=> upd_busy);
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int HDIV_W    = 5,
  parameter int CDIV_W    = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_SLOTS + ADDR_CDIV0)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 upd_start,
  input  logic                 err_clr,
  input  logic                 cmd_busy,
  input  logic [NUM_SLOTS-1:0] slot_busy,
  output logic                 upd_busy,
  output logic                 lock_err,
  output logic [NUM_SLOTS-1:0] card_clk
);
  logic                             load, tick;
  logic [HDIV_W-1:0]                live_hdiv;
  logic [NUM_SLOTS-1:0][CDIV_W-1:0] live_cdiv;
  logic [NUM_SLOTS-1:0]             live_en, live_lp;

  card_clk_upd #(
    .NUM_SLOTS(NUM_SLOTS), .HDIV_W(HDIV_W), .CDIV_W(CDIV_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_upd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_start(upd_start), .err_clr(err_clr), .cmd_busy(cmd_busy),
    .any_high(|card_clk), .load(load), .upd_busy(upd_busy), .lock_err(lock_err),
    .live_hdiv(live_hdiv), .live_cdiv(live_cdiv), .live_en(live_en), .live_lp(live_lp)
  );

  card_clk_host_div #(.HDIV_W(HDIV_W)) u_host (
    .clk(clk), .rst(rst), .load(load), .hdiv(live_hdiv), .tick(tick)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    card_clk_slot #(.CDIV_W(CDIV_W)) u_slot (
      .clk(clk), .rst(rst), .load(load), .tick(tick), .cdiv(live_cdiv[i]),
      .en(live_en[i]), .lp(live_lp[i]), .busy(slot_busy[i]), .card_clk(card_clk[i])
    );
  end
endmodule

// File: tb/test_card_clk_gen.sv
module test_card_clk_gen;
  localparam int NS = 2;
  localparam int DW = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, wr_en = 1'b0, upd_start = 1'b0, err_clr = 1'b0, cmd_busy = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NS-1:0] slot_busy = '0;
  logic upd_busy, lock_err;
  logic [NS-1:0] card_clk;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  card_clk_gen i_card_clk_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_start(upd_start), .err_clr(err_clr), .cmd_busy(cmd_busy),
    .slot_busy(slot_busy), .upd_busy(upd_busy), .lock_err(lock_err), .card_clk(card_clk)
  );

  // host divider, card divider, expected period
  localparam int VEC [0:7][0:2] = '{
    '{1, 0, 2}, '{4, 0, 8}, '{3, 0, 6}, '{8, 0, 16},
    '{2, 1, 4}, '{10, 20, 400}, '{16, 2, 64}, '{5, 3, 30}};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_update();
    int k = 0;
    @(negedge clk); upd_start = 1'b1;
    @(negedge clk); upd_start = 1'b0;
    check("R6 start bit set", int'(upd_busy), 1);
    while (upd_busy && k < 5000) begin @(negedge clk); k++; end
    check("R6 start bit clears", int'(upd_busy), 0);
  endtask

  task automatic measure(int s, output int per, output int hi);
    int g = 0, lo = 0;
    logic prev;
    prev = card_clk[s];
    forever begin
      @(negedge clk); g++;
      if (!prev && card_clk[s]) break;
      prev = card_clk[s];
      if (g > 3000) break;
    end
    hi = 0;
    while (card_clk[s] && hi < 3000) begin @(negedge clk); hi++; end
    while (!card_clk[s] && lo < 3000) begin @(negedge clk); lo++; end
    per = hi + lo;
  endtask

  task automatic count_high(int s, int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (card_clk[s]) highs++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int per, hi, highs;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 card_clk after reset", int'(card_clk), 0);
    check("R1 upd_busy after reset", int'(upd_busy), 0);
    check("R1 lock_err after reset", int'(lock_err), 0);
    count_high(0, 20, highs);
    check("R1 clocks stay low", highs, 0);
    // R1 zero dividers: enable slot 0 only
    wr(1, 1);
    do_update();
    measure(0, per, hi);
    check("R1 zero-divider period", per, 2);

    // R2 R3 vector table on slot 0
    foreach (VEC[v]) begin
      wr(0, VEC[v][0]);
      wr(2, VEC[v][1]);
      do_update();
      measure(0, per, hi);
      check($sformatf("R2/R3 period vec%0d", v), per, VEC[v][2]);
      check($sformatf("R10 high width vec%0d", v), hi, VEC[v][2] / 2);
    end

    // R5 shadow write without update has no effect (last vector 5,3 -> 30)
    wr(0, 2);
    measure(0, per, hi);
    check("R5 period unchanged before update", per, 30);
    do_update();
    measure(0, per, hi);
    check("R5 new period after update", per, 12);

    // R4 independent slot dividers: H=2, slot0 M=1, slot1 M=3
    wr(2, 1);
    wr(3, 3);
    wr(1, 3);
    do_update();
    measure(0, per, hi);
    check("R4 slot0 period", per, 4);
    measure(1, per, hi);
    check("R4 slot1 period", per, 12);
    check("R10 slot1 high width", hi, 6);

    // R8 disable slot 0, slot 1 keeps running
    wr(1, 2);
    do_update();
    count_high(0, 60, highs);
    check("R8 disabled slot0 low", highs, 0);
    measure(1, per, hi);
    check("R8 slot1 still running", per, 12);

    // R7 refused request while command path busy
    wr(1, 3);
    @(negedge clk); cmd_busy = 1'b1; upd_start = 1'b1;
    @(negedge clk); upd_start = 1'b0; cmd_busy = 1'b0;
    check("R7 lock_err set", int'(lock_err), 1);
    check("R7 start bit clear on refusal", int'(upd_busy), 0);
    count_high(0, 60, highs);
    check("R7 nothing loaded", highs, 0);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R7 lock_err cleared", int'(lock_err), 0);
    do_update();
    measure(0, per, hi);
    check("R7 retry loads", per, 4);

    // R9 low power: slot0 enabled with lp, slot idle
    slot_busy = 2'b00;
    wr(1, 32'h5);
    do_update();
    count_high(0, 60, highs);
    check("R9 idle low-power slot low", highs, 0);
    @(negedge clk); slot_busy = 2'b01;
    measure(0, per, hi);
    check("R9 busy low-power slot runs", per, 4);
    check("R10 high width after ungating", hi, 2);
    @(negedge clk); slot_busy = 2'b00;
    repeat (4) @(negedge clk);
    count_high(0, 40, highs);
    check("R9 stops again when idle", highs, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule